// File: doc/BRIEF.md
# Dual-Rail Four-Phase Token Pipeline

This block is a chain of one-bit pipeline stages. Each stage carries its bit as a dual-rail token and passes it on with a four-phase, return-to-zero handshake. Every stage is in one of three conditions: empty, holding a zero, or holding a one. Because of the empty condition, extra stages can be placed in a chain without creating tokens. Such stages add delay but do not change the stream of values that reaches the far end.

The chain is modelled synchronously. One clock samples all handshake wires, and a synchronous active-high reset loads each stage from two configuration vectors. The first vector says whether the stage starts holding a token, like a register. The second gives that token's value. A stage that starts empty behaves as a repeater, but it can still capture and hold a token later.

The input end presents two rails and returns an acknowledge. The output end presents two rails and receives an acknowledge from the consumer. Any illegal input code is flagged.

Top module: `dr_pipe_chain`

## Requirements
- R1: Rail code on every rail pair `[1:0]`: 2'b00 means no data, 2'b10 is a 0 token, 2'b01 is a 1 token, and 2'b11 is illegal.
- R2: While reset is high, `up_ack` and `rail_err` are low. Each stage k loads a token of value `cfg_val[k]` when `cfg_full[k]` is 1, and loads empty otherwise. Stage 0 is at the input end and stage NSTAGES-1 at the output end.
- R3: `dn_rails` shows the R1 code of the token held by the last stage, and shows 2'b00 when that stage is empty.
- R4: A stage captures a valid token only when it is empty, its own acknowledge is low and its downstream acknowledge is low. Its acknowledge rises on the clock edge where it captures, so `up_ack` is high at the first sample after valid rails are applied to an empty, idle chain.
- R5: A raised acknowledge stays high while the input rails still carry the token. It falls on the edge after the rails return to 2'b00.
- R6: A held token stays on the stage's output until the downstream acknowledge is high. The stage then becomes empty on the next edge.
- R7: Input code 2'b11 is never captured, so `up_ack` stays low. It sets `rail_err` one edge later, and `rail_err` stays set until reset.
- R8: The chain delivers, in order, the initial tokens starting from the output end, then every injected token. This holds for any initialisation pattern.
- R9: `cfg_full` and `cfg_val` have no effect outside reset. Changing them mid-run leaves the delivered stream unchanged.
- R10: A chain with every stage empty adds latency only. It delivers exactly the injected stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_full | input | NSTAGES | Per-stage start-with-token select |
| cfg_val | input | NSTAGES | Per-stage initial token value |
| up_rails | input | 2 | Input dual-rail code |
| up_ack | output | 1 | Acknowledge returned to the producer |
| dn_rails | output | 2 | Output dual-rail code |
| dn_ack | input | 1 | Acknowledge from the consumer |
| rail_err | output | 1 | Sticky illegal-input-code flag |

## Verification
The main function is tried with these initialisation patterns, each followed by a random token stream while producer and consumer stall at random:
- All stages empty. This separates pure latency from token insertion.
- All stages full. This checks that initial tokens leave in output-end-first order.
- Alternating full and empty stages, with random values. This tells a correct shift apart from a stage that skips over or overwrites a neighbour.

Directed cases then look at single-token timing:
- The acknowledge rising and falling.
- A token parked at the output while the consumer holds off.
- The illegal code held on the input.

Scrambling the configuration vectors mid-run separates reset-only loading from live use of the configuration.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_ZERO = 2'd1,
        TK_ONE  = 2'd2
    } tok_e;

    localparam logic [1:0] RAIL_NONE = 2'b00;
    localparam logic [1:0] RAIL_ZERO = 2'b10;
    localparam logic [1:0] RAIL_ONE  = 2'b01;
    localparam logic [1:0] RAIL_BAD  = 2'b11;

    function automatic logic [1:0] tok_to_rails(input tok_e t);
        case (t)
            TK_ZERO: tok_to_rails = RAIL_ZERO;
            TK_ONE:  tok_to_rails = RAIL_ONE;
            default: tok_to_rails = RAIL_NONE;
        endcase
    endfunction

    function automatic tok_e rails_to_tok(input logic [1:0] r);
        case (r)
            RAIL_ZERO: rails_to_tok = TK_ZERO;
            RAIL_ONE:  rails_to_tok = TK_ONE;
            default:   rails_to_tok = TK_NONE;
        endcase
    endfunction

    function automatic logic rails_valid(input logic [1:0] r);
        rails_valid = (r == RAIL_ZERO) || (r == RAIL_ONE);
    endfunction

    function automatic tok_e init_tok(input logic full, input logic val);
        if (!full)
            init_tok = TK_NONE;
        else if (val)
            init_tok = TK_ONE;
        else
            init_tok = TK_ZERO;
    endfunction

endpackage

// File: rtl/dr_rail_mon.sv
module dr_rail_mon
    import dr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rails,
    output logic       err
);

    logic bad_now;

    assign bad_now = (rails == RAIL_BAD);

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (bad_now)
            err <= 1'b1;
    end

    // R7
    bad_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rails == RAIL_BAD) |=> err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import dr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_full,
    input  logic       cfg_val,
    input  logic [1:0] in_rails,
    output logic       in_ack,
    output logic [1:0] out_rails,
    input  logic       out_ack
);

    tok_e held;
    logic ack_q;
    logic take;
    logic in_empty;

    assign in_empty = (in_rails == RAIL_NONE);
    assign take     = (held == TK_NONE) && !ack_q && !out_ack && rails_valid(in_rails);

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= init_tok(cfg_full, cfg_val);
            ack_q <= 1'b0;
        end else begin
            if (held == TK_NONE) begin
                if (take)
                    held <= rails_to_tok(in_rails);
            end else if (out_ack) begin
                held <= TK_NONE;
            end

            if (!ack_q && take)
                ack_q <= 1'b1;
            else if (ack_q && in_empty)
                ack_q <= 1'b0;
        end
    end

    assign in_ack    = ack_q;
    assign out_rails = tok_to_rails(held);

    // R4
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ack) |-> $past(rails_valid(in_rails) && !out_ack));

    // R5
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ack) |-> $past(in_rails == RAIL_NONE));

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (out_rails != RAIL_NONE && !out_ack) |=> $stable(out_rails));

    // R1
    out_code_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_rails));

    // R4
    capture_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_rails != RAIL_NONE) |-> $past(!out_ack && !in_ack));

endmodule

// File: rtl/dr_pipe_chain.sv
module dr_pipe_chain
    import dr_pkg::*;
#(
    parameter int NSTAGES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTAGES-1:0] cfg_full,
    input  logic [NSTAGES-1:0] cfg_val,
    input  logic [1:0]         up_rails,
    output logic               up_ack,
    output logic [1:0]         dn_rails,
    input  logic               dn_ack,
    output logic               rail_err
);

    localparam int NLINKS = NSTAGES + 1;

    logic [1:0] lnk_rails [NLINKS];
    logic       lnk_ack   [NLINKS];

    assign lnk_rails[0]       = up_rails;
    assign lnk_ack[NSTAGES]   = dn_ack;
    assign up_ack             = lnk_ack[0];
    assign dn_rails           = lnk_rails[NSTAGES];

    genvar gi;
    generate
        for (gi = 0; gi < NSTAGES; gi++) begin : g_stage
            dr_stage u_stage (
                .clk       (clk),
                .rst       (rst),
                .cfg_full  (cfg_full[gi]),
                .cfg_val   (cfg_val[gi]),
                .in_rails  (lnk_rails[gi]),
                .in_ack    (lnk_ack[gi]),
                .out_rails (lnk_rails[gi+1]),
                .out_ack   (lnk_ack[gi+1])
            );
        end
    endgenerate

    dr_rail_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .rails (up_rails),
        .err   (rail_err)
    );

    // R7
    no_bad_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (up_rails == RAIL_BAD && !up_ack) |=> !up_ack);

endmodule

// File: tb/sim_dr_pipe_chain.sv
module sim_dr_pipe_chain;

    localparam int N = 4;
    localparam int QMAX = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cfg_full = '0;
    logic [N-1:0] cfg_val  = '0;
    logic [1:0]   up_rails = 2'b00;
    logic         up_ack;
    logic [1:0]   dn_rails;
    logic         dn_ack = 1'b0;
    logic         rail_err;

    int n_tests = 0;
    int n_fail  = 0;

    logic exp_q [QMAX];
    int   exp_n;
    int   got_n;
    logic scramble;

    always #5 clk = ~clk;

    dr_pipe_chain #(.NSTAGES(N)) u0 (
        .clk(clk), .rst(rst), .cfg_full(cfg_full), .cfg_val(cfg_val),
        .up_rails(up_rails), .up_ack(up_ack), .dn_rails(dn_rails),
        .dn_ack(dn_ack), .rail_err(rail_err)
    );

    function automatic logic [1:0] code_of(input logic v);
        return v ? 2'b01 : 2'b10;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [N-1:0] f, input logic [N-1:0] v);
        up_rails = 2'b00;
        dn_ack   = 1'b0;
        cfg_full = f;
        cfg_val  = v;
        rst      = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic v);
        while (up_ack) @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
        if (scramble) begin
            cfg_full = N'($urandom);
            cfg_val  = N'($urandom);
        end
        up_rails = code_of(v);
        @(negedge clk);
        while (!up_ack) @(negedge clk);
        repeat ($urandom % 3) @(negedge clk);
        up_rails = 2'b00;
        @(negedge clk);
    endtask

    task automatic receive_all(input string req);
        while (got_n < exp_n) begin
            @(negedge clk);
            if (($urandom % 4) != 0) begin
                if (!dn_ack && (dn_rails == 2'b10 || dn_rails == 2'b01)) begin
                    check(req, dn_rails, code_of(exp_q[got_n]));
                    got_n++;
                    dn_ack = 1'b1;
                end else if (dn_ack && dn_rails == 2'b00) begin
                    dn_ack = 1'b0;
                end
            end
        end
        while (dn_ack) begin
            @(negedge clk);
            if (dn_rails == 2'b00) dn_ack = 1'b0;
        end
    endtask

    // Stream case: reset with a pattern, then inject ntok random tokens.
    task automatic run_case(input string req, input logic [N-1:0] f,
                            input logic [N-1:0] v, input int ntok, input logic scr);
        logic inj [QMAX];
        logic [1:0] head;
        scramble = 1'b0;
        do_reset(f, v);
        // R2: reset state at the ports
        check("R2 up_ack", up_ack, 1'b0);
        check("R2 rail_err", rail_err, 1'b0);
        head = f[N-1] ? code_of(v[N-1]) : 2'b00;
        // R3: head stage shown on output rails
        check("R3 head", dn_rails, head);
        exp_n = 0;
        got_n = 0;
        for (int i = N-1; i >= 0; i--) begin
            if (f[i]) begin
                exp_q[exp_n] = v[i];
                exp_n++;
            end
        end
        for (int i = 0; i < ntok; i++) begin
            inj[i] = 1'($urandom);
            exp_q[exp_n] = inj[i];
            exp_n++;
        end
        scramble = scr;
        fork
            begin
                for (int i = 0; i < ntok; i++) send(inj[i]);
            end
            receive_all(req);
        join
        check({req, " count"}, got_n, exp_n);
        check({req, " err"}, rail_err, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        scramble = 1'b0;

        // R10: all empty chain, latency only
        run_case("R10", 4'b0000, 4'b0000, 12, 1'b0);
        // R8: all full, both values
        run_case("R8 full", 4'b1111, 4'b0110, 10, 1'b0);
        // R8: alternating occupancy
        run_case("R8 alt", 4'b0101, 4'b0001, 10, 1'b0);
        run_case("R8 alt2", 4'b1010, 4'b1000, 10, 1'b0);
        // R8: random patterns
        for (int k = 0; k < 6; k++)
            run_case("R8 rnd", N'($urandom), N'($urandom), 8 + (k % 4), 1'b0);
        // R9: configuration scrambled mid-run
        run_case("R9", 4'b1001, 4'b0001, 12, 1'b1);
        scramble = 1'b0;

        // R4 / R5 / R6 directed single token
        do_reset(4'b0000, 4'b0000);
        up_rails = 2'b01;
        @(negedge clk);
        // R4: ack high one edge after valid rails
        check("R4 ack rise", up_ack, 1'b1);
        repeat (3) @(negedge clk);
        // R5: ack stays high while rails held
        check("R5 ack held", up_ack, 1'b1);
        up_rails = 2'b00;
        @(negedge clk);
        // R5: ack falls one edge after rails return to zero
        check("R5 ack fall", up_ack, 1'b0);
        repeat (20) @(negedge clk);
        // R6: token parked at output while consumer holds off
        check("R6 parked", dn_rails, 2'b01);
        repeat (5) @(negedge clk);
        check("R6 still", dn_rails, 2'b01);
        dn_ack = 1'b1;
        @(negedge clk);
        // R6: empties one edge after downstream ack
        check("R6 release", dn_rails, 2'b00);
        dn_ack = 1'b0;
        @(negedge clk);

        // R7: illegal code
        do_reset(4'b0000, 4'b0000);
        up_rails = 2'b11;
        @(negedge clk);
        check("R7 err set", rail_err, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 no ack", up_ack, 1'b0);
        repeat (N + 2) @(negedge clk);
        check("R7 no token", dn_rails, 2'b00);
        up_rails = 2'b00;
        @(negedge clk);
        check("R7 sticky", rail_err, 1'b1);
        // R1: a legal zero token after the illegal one still passes
        up_rails = 2'b10;
        @(negedge clk);
        check("R1 zero ack", up_ack, 1'b1);
        up_rails = 2'b00;
        repeat (N + 4) @(negedge clk);
        check("R1 zero code", dn_rails, 2'b10);
        do_reset(4'b0000, 4'b0000);
        check("R7 cleared", rail_err, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule